// File: doc/BRIEF.md
# Multi-layer packet ejection merger

In a stacked-die network every processor tile can receive traffic from the router on each of several device layers. This block collects those streams into the single ejection port of one processor. Each layer input has its own small flit buffer and returns one credit to its router every time a flit leaves that buffer. The upstream router only sends a flit while it holds a credit, so a buffer is never written while full.

A round-robin arbiter decides which layer's packet goes to the processor. Once a packet's first flit has been accepted, the arbiter stays on that layer until the packet's last flit has been forwarded. Flits of different packets therefore never mix at the output. The virtual channel tag of the packet's first flit is recorded and every later flit of the packet must carry the same tag. The output uses a valid/ready handshake. A processor that holds ready low freezes the presented flit and the buffer behind it, and no flit is lost.

Each flit carries a head bit, a tail bit, a virtual channel tag and a data word. A packet is one or more flits, five by default. Its first flit has head set and its last flit has tail set. A one-flit packet has both bits set.

Top module: `lmx_eject_merge`

## Requirements
- R1: While reset is applied and in the first cycle after it, `out_valid` is 0 and `lyr_credit` is all zeros.
- R2: With `out_ready` held low, each layer input stores up to DEPTH (default 5) flits without loss. The upstream side never writes a full buffer. Once the output is released, all stored flits are delivered.
- R3: `lyr_credit[i]` pulses high for exactly the cycles in which a flit from layer i is accepted at the output (`out_valid && out_ready`, `out_layer == i`). At most one credit bit is high in any cycle.
- R4: A new packet is granted to the first layer holding a flit, searching upward from the layer that most recently started a packet and wrapping from the highest layer to layer 0. After reset the search starts at layer 0.
- R5: Between the accepted head flit of a multi-flit packet and its tail flit, every flit accepted at the output comes from the same layer and carries the same `out_vc`.
- R6: Flits from one layer leave in arrival order. Their head, tail, virtual channel and data fields are unchanged.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` at 1 with the same `out_data`, `out_vc` and `out_layer`.
- R8: A one-flit packet (head = 1 and tail = 1) does not hold the arbiter. The next packet is chosen by R4 right after it. Any flit accepted while no packet is in progress is a head flit.
- R9: After all traffic has drained, the number of credits returned to each layer equals the number of flits it sent. An upstream credit counter starting at DEPTH therefore ends at DEPTH again.
- R10: `out_layer` gives the index (0 to NL-1) of the layer that supplied the flit on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lyr_valid | input | NL | Flit present on the input of each layer |
| lyr_head | input | NL | Head-of-packet bit, one per layer |
| lyr_tail | input | NL | End-of-packet bit, one per layer |
| lyr_vc | input | NL*VC_W | Virtual channel tag for each layer, layer i at bits [i*VC_W +: VC_W] |
| lyr_data | input | NL*DATA_W | Flit payload for each layer, layer i at bits [i*DATA_W +: DATA_W] |
| lyr_credit | output | NL | One-cycle credit return for each layer |
| out_valid | output | 1 | Flit presented to the processor |
| out_ready | input | 1 | Processor accepts the presented flit |
| out_head | output | 1 | Head bit of the presented flit |
| out_tail | output | 1 | Tail bit of the presented flit |
| out_vc | output | VC_W | Virtual channel tag of the presented flit |
| out_data | output | DATA_W | Payload of the presented flit |
| out_layer | output | IW | Source layer of the presented flit |

## Verification
The assertions assume that each layer is written only while its router holds a credit, so no buffer overflows. They also assume that each layer delivers its packets whole and one after another, with a constant virtual channel tag inside a packet and a head flit at the start of each packet.

The bench keeps one credit counter per layer, starting at DEPTH. A layer sends only while its counter is above zero, and the counter is refilled from the credit pulses. Each layer's packets are sent in sequence from one process, which keeps every packet contiguous and uniform in tag. Stalls come from holding `out_ready` low or from a pseudo-random ready pattern, so the buffers fill up without ever being overrun.

// File: rtl/lmx_pkg.sv
package lmx_pkg;

  localparam int MAX_LAYERS = 16;

  typedef enum logic [1:0] {
    ARB_FREE = 2'd0,
    ARB_HOLD = 2'd1,
    ARB_LOCK = 2'd2
  } arb_state_e;

  // Next index of a circular counter of size lim.
  function automatic int wrap_inc(input int p, input int lim);
    return (p + 1 >= lim) ? 0 : p + 1;
  endfunction

  // First set bit of req above 'last', wrapping; -1 when req is empty.
  function automatic int rr_pick(input logic [MAX_LAYERS-1:0] req,
                                 input int last, input int n);
    int r;
    int idx;
    r   = -1;
    idx = last;
    for (int off = 0; off < MAX_LAYERS; off++) begin
      if (off < n) begin
        idx = wrap_inc(idx, n);
        if (r < 0 && req[idx]) r = idx;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/lmx_flit_fifo.sv
module lmx_flit_fifo #(
  parameter int DEPTH = 5,
  parameter int W     = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  import lmx_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // Upstream honours credits: a full buffer is never written.
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // Only a buffered flit can be forwarded.
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/lmx_rr_pick.sv
module lmx_rr_pick #(
  parameter int NL   = 4,
  parameter int VC_W = 2,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NL-1:0]   req,
  input  logic            out_ready,
  input  logic            front_head,
  input  logic            front_tail,
  input  logic [VC_W-1:0] front_vc,
  output logic [IW-1:0]   sel,
  output logic            sel_valid,
  output logic            fire
);
  import lmx_pkg::*;

  arb_state_e             st;
  logic [IW-1:0]          cur_idx;
  logic [IW-1:0]          last_idx;
  logic [VC_W-1:0]        cur_vc;
  logic [MAX_LAYERS-1:0]  req_wide;
  int                     pick_i;

  assign req_wide = MAX_LAYERS'(req);

  always_comb begin
    pick_i = rr_pick(req_wide, int'(last_idx), NL);
    if (st == ARB_FREE) begin
      sel       = IW'(pick_i);
      sel_valid = |req;
    end else begin
      sel       = cur_idx;
      sel_valid = req[cur_idx];
    end
  end

  assign fire = sel_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ARB_FREE;
      cur_idx  <= '0;
      last_idx <= IW'(NL - 1);
      cur_vc   <= '0;
    end else begin
      case (st)
        ARB_FREE, ARB_HOLD: begin
          if (fire) begin
            last_idx <= sel;
            cur_idx  <= sel;
            cur_vc   <= front_vc;
            st       <= front_tail ? ARB_FREE : ARB_LOCK;
          end else if (sel_valid) begin
            cur_idx <= sel;
            st      <= ARB_HOLD;
          end
        end
        ARB_LOCK: begin
          if (fire && front_tail) st <= ARB_FREE;
        end
        default: st <= ARB_FREE;
      endcase
    end
  end

  // A stalled offer keeps its layer until taken.
  p_hold_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !out_ready) |=> (sel_valid && sel == $past(sel)));

  // Body flits of a locked packet keep the head flit's channel tag.
  p_lock_vc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARB_LOCK && fire) |-> (front_vc == cur_vc));

  // A flit taken with no packet in progress opens a packet.
  p_free_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ARB_LOCK && fire) |-> front_head);

endmodule

// File: rtl/lmx_eject_merge.sv
module lmx_eject_merge #(
  parameter int NL     = 4,
  parameter int DEPTH  = 5,
  parameter int VC_W   = 2,
  parameter int DATA_W = 16,
  parameter int IW     = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NL-1:0]        lyr_valid,
  input  logic [NL-1:0]        lyr_head,
  input  logic [NL-1:0]        lyr_tail,
  input  logic [NL*VC_W-1:0]   lyr_vc,
  input  logic [NL*DATA_W-1:0] lyr_data,
  output logic [NL-1:0]        lyr_credit,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_head,
  output logic                 out_tail,
  output logic [VC_W-1:0]      out_vc,
  output logic [DATA_W-1:0]    out_data,
  output logic [IW-1:0]        out_layer
);

  localparam int FW = 2 + VC_W + DATA_W;

  logic [FW-1:0] front [NL];
  logic [NL-1:0] empty_v;
  logic [NL-1:0] full_v;
  logic [NL-1:0] pop_v;
  logic [NL-1:0] req;
  logic [IW-1:0] sel;
  logic          sel_valid;
  logic          fire;
  logic [FW-1:0] sel_flit;

  assign req = ~empty_v;

  for (genvar i = 0; i < NL; i++) begin : g_layer
    logic [FW-1:0] din;
    assign din      = {lyr_head[i], lyr_tail[i],
                       lyr_vc[i*VC_W +: VC_W], lyr_data[i*DATA_W +: DATA_W]};
    assign pop_v[i] = fire && (sel == IW'(i));

    lmx_flit_fifo #(.DEPTH(DEPTH), .W(FW)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (lyr_valid[i]),
      .din   (din),
      .pop   (pop_v[i]),
      .dout  (front[i]),
      .empty (empty_v[i]),
      .full  (full_v[i])
    );
  end

  assign sel_flit = front[sel];

  lmx_rr_pick #(.NL(NL), .VC_W(VC_W), .IW(IW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .out_ready  (out_ready),
    .front_head (sel_flit[FW-1]),
    .front_tail (sel_flit[FW-2]),
    .front_vc   (sel_flit[DATA_W +: VC_W]),
    .sel        (sel),
    .sel_valid  (sel_valid),
    .fire       (fire)
  );

  assign out_valid  = sel_valid;
  assign out_head   = sel_flit[FW-1];
  assign out_tail   = sel_flit[FW-2];
  assign out_vc     = sel_flit[DATA_W +: VC_W];
  assign out_data   = sel_flit[DATA_W-1:0];
  assign out_layer  = sel;
  assign lyr_credit = pop_v;

  // One credit per accepted flit, none otherwise.
  p_credit_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lyr_credit) == ((out_valid && out_ready) ? 1 : 0));

  // The credit goes to the layer reported on the output.
  p_credit_layer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> lyr_credit[out_layer]);

  // A stalled flit stays on the port unchanged.
  p_out_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_vc) && $stable(out_layer)));

  // An accepted body or tail flit comes from the layer of the flit before it.
  p_lock_layer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_head) |-> (out_layer == u_arb.cur_idx));

endmodule

// File: tb/lmx_eject_merge_tb.sv
module lmx_eject_merge_tb;

  localparam int NL = 4;
  localparam int DEPTH = 5;
  localparam int VC_W = 2;
  localparam int DATA_W = 16;
  localparam int IW = 2;
  localparam int EW = 2 + VC_W + DATA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                 v_l [NL];
  logic                 h_l [NL];
  logic                 t_l [NL];
  logic [VC_W-1:0]      c_l [NL];
  logic [DATA_W-1:0]    d_l [NL];

  logic [NL-1:0]        lyr_valid, lyr_head, lyr_tail, lyr_credit;
  logic [NL*VC_W-1:0]   lyr_vc;
  logic [NL*DATA_W-1:0] lyr_data;
  logic                 out_valid, out_ready, out_head, out_tail;
  logic [VC_W-1:0]      out_vc;
  logic [DATA_W-1:0]    out_data;
  logic [IW-1:0]        out_layer;

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      lyr_valid[i]                 = v_l[i];
      lyr_head[i]                  = h_l[i];
      lyr_tail[i]                  = t_l[i];
      lyr_vc[i*VC_W +: VC_W]       = c_l[i];
      lyr_data[i*DATA_W +: DATA_W] = d_l[i];
    end
  end

  lmx_eject_merge #(.NL(NL), .DEPTH(DEPTH), .VC_W(VC_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lyr_valid(lyr_valid), .lyr_head(lyr_head), .lyr_tail(lyr_tail),
    .lyr_vc(lyr_vc), .lyr_data(lyr_data), .lyr_credit(lyr_credit),
    .out_valid(out_valid), .out_ready(out_ready), .out_head(out_head),
    .out_tail(out_tail), .out_vc(out_vc), .out_data(out_data),
    .out_layer(out_layer)
  );

  int checks = 0;
  int errors = 0;
  int cred [NL];
  int sent [NL];
  int got  [NL];
  logic [EW-1:0] expq [NL][$];
  int exp_start [$];
  bit rnd_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Upstream credit counters: spend on send, refill on credit pulse.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) cred[i] <= DEPTH;
    end else begin
      for (int i = 0; i < NL; i++)
        cred[i] <= cred[i] - int'(v_l[i]) + int'(lyr_credit[i]);
    end
  end

  // Pseudo-random ready pattern for the stress phase.
  always @(posedge clk) begin
    #1;
    if (rnd_en) begin
      lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[2];
    end
  end

  // Driver: one packet on one layer; expected flits go to that layer's queue.
  task automatic send_pkt(input int l, input int vc, input int len, input int tag);
    for (int k = 0; k < len; k++) begin
      while (cred[l] == 0) begin
        @(posedge clk); #1;
      end
      v_l[l] = 1'b1;
      h_l[l] = (k == 0);
      t_l[l] = (k == len - 1);
      c_l[l] = VC_W'(vc);
      d_l[l] = {4'(l), 8'(tag), 4'(k)};
      expq[l].push_back({h_l[l], t_l[l], c_l[l], d_l[l]});
      sent[l]++;
      @(posedge clk); #1;
      v_l[l] = 1'b0;
    end
  endtask

  // Monitor / scoreboard.
  bit            stall_prev = 1'b0;
  logic [DATA_W-1:0] pdata;
  logic [IW-1:0] player;
  bit            mlock = 1'b0;
  int            mlayer = 0;
  int            mvc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit fire = out_valid && out_ready;
      automatic logic [NL-1:0] expc = fire ? (NL'(1) << out_layer) : '0;
      check(lyr_credit == expc, "R3 credit pulse", int'(lyr_credit), int'(expc));
      if (stall_prev)
        check(out_valid && out_data == pdata && out_layer == player,
              "R7 stalled flit held", int'(out_data), int'(pdata));
      stall_prev = out_valid && !out_ready;
      pdata  = out_data;
      player = out_layer;
      if (fire) begin
        automatic int l = int'(out_layer);
        got[l]++;
        check(int'(out_data[15:12]) == l, "R10 source layer", l, int'(out_data[15:12]));
        if (expq[l].size() == 0) begin
          check(1'b0, "R6 unexpected flit", int'(out_data), -1);
        end else begin
          automatic logic [EW-1:0] e = expq[l].pop_front();
          check({out_head, out_tail, out_vc, out_data} == e, "R6 order and fields",
                int'({out_head, out_tail, out_vc, out_data}), int'(e));
        end
        if (mlock)
          check(l == mlayer && int'(out_vc) == mvc, "R5 packet atomic", l, mlayer);
        else
          check(out_head, "R8 head when free", int'(out_head), 1);
        if (out_head && exp_start.size() > 0) begin
          automatic int es = exp_start.pop_front();
          check(l == es, "R4 round-robin start", l, es);
        end
        if (out_head && !out_tail) begin
          mlock = 1'b1; mlayer = l; mvc = int'(out_vc);
        end
        if (out_tail) mlock = 1'b0;
      end
    end
  end

  task automatic wait_drain();
    int guard;
    guard = 0;
    while ((expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size()) != 0
           && guard < 5000) begin
      @(posedge clk); guard++;
    end
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      v_l[i] = 0; h_l[i] = 0; t_l[i] = 0; c_l[i] = '0; d_l[i] = '0;
      sent[i] = 0; got[i] = 0;
    end
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    check(lyr_credit == '0, "R1 no credit in reset", int'(lyr_credit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(lyr_credit == '0, "R1 no credit after reset", int'(lyr_credit), 0);
    @(posedge clk); #1;

    // R2: fill layer 2 to depth under stall, then drain.
    exp_start.push_back(2);
    send_pkt(2, 1, 5, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid && out_layer == 2, "R2 buffered flit offered", int'(out_layer), 2);
    check(cred[2] == 0, "R2 five flits held", cred[2], 0);
    @(posedge clk); #1;
    out_ready = 1'b1;
    wait_drain();
    check(got[2] == 5, "R2 all stored flits delivered", got[2], 5);

    // R4: all four layers pending; last start was layer 2 -> 3,0,1,2.
    out_ready = 1'b0;
    exp_start.push_back(3); exp_start.push_back(0);
    exp_start.push_back(1); exp_start.push_back(2);
    fork
      send_pkt(0, 0, 2, 2);
      send_pkt(1, 1, 2, 3);
      send_pkt(2, 2, 2, 4);
      send_pkt(3, 3, 2, 5);
    join
    repeat (3) @(posedge clk); #1;
    out_ready = 1'b1;
    wait_drain();

    // R4: layers 0 and 2 pending, last start 2 -> 0 then 2.
    out_ready = 1'b0;
    exp_start.push_back(0); exp_start.push_back(2);
    fork
      send_pkt(2, 3, 3, 6);
      send_pkt(0, 1, 4, 7);
    join
    repeat (3) @(posedge clk); #1;
    out_ready = 1'b1;
    wait_drain();

    // R8: one-flit packet on layer 3 must not hold the arbiter -> 3,0,1.
    out_ready = 1'b0;
    exp_start.push_back(3); exp_start.push_back(0); exp_start.push_back(1);
    fork
      send_pkt(3, 2, 1, 8);
      send_pkt(0, 0, 3, 9);
      send_pkt(1, 3, 2, 10);
    join
    repeat (3) @(posedge clk); #1;
    out_ready = 1'b1;
    wait_drain();

    // Stress: all layers, mixed lengths and tags, random back-pressure.
    rnd_en = 1'b1;
    fork
      for (int p = 0; p < 8; p++) send_pkt(0, p % 4, (p % 5) + 1, 20 + p);
      for (int p = 0; p < 8; p++) send_pkt(1, (p + 1) % 4, 5, 40 + p);
      for (int p = 0; p < 8; p++) send_pkt(2, (p + 2) % 4, ((p + 3) % 5) + 1, 60 + p);
      for (int p = 0; p < 8; p++) send_pkt(3, (p + 3) % 4, (p % 2) ? 1 : 5, 80 + p);
    join
    wait_drain();
    rnd_en = 1'b0;
    #1 out_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    for (int i = 0; i < NL; i++) begin
      check(cred[i] == DEPTH, "R9 credits restored", cred[i], DEPTH);
      check(got[i] == sent[i], "R9 flits out equal flits in", got[i], sent[i]);
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule